// File: doc/BRIEF.md
# Completion Status and Control Register

This block is the status and control register of an accelerator that reports the end of work in two ways: through an engine done flag and through a flag for completed DMA transfers. The datapath sends single-cycle pulses when the engine finishes, when it hits an error, when a new operation starts, and when a DMA transfer completes. It also drives a level that shows whether the engine is busy. Software reads and writes one register word through a plain write-enable bus. Reads are combinational.

Two configuration bits set how the flags behave. A routing mask decides whether DMA completion also raises the done flag. An access-mode bit decides whether software clears the DMA flag by writing a 1, or writes it directly to either value. The access-mode bit sits in the power-on reset domain, so an ordinary system reset leaves it unchanged. The `irq` output is a level copy of the done flag.

Top module: `cmpl_status_reg`

## Requirements
- R1: After a system reset (`rst_n` low) or a power-on reset (`por_n` low), done (bit 0), error (bit 2), DMA flag (bit 4) and routing mask (bit 8) read 0. After a power-on reset, the access-mode bit (bit 9) also reads 0.
- R2: Ready (bit 1) reads 1 in the same cycle that `eng_busy` is 0, and reads 0 while `eng_busy` is 1.
- R3: An `eng_done` pulse sets done in the next cycle. Done then stays set until software writes 1 to bit 0 or an `eng_start` pulse arrives. A set in the same cycle as a clear wins.
- R4: An `eng_err` pulse sets error in the next cycle. Error stays set until software writes 1 to bit 2 or an `eng_start` pulse arrives. A set in the same cycle as a clear wins.
- R5: A `dma_cmpl` pulse sets the DMA flag in the next cycle, whatever the routing mask holds.
- R6: With the mask at 1, a `dma_cmpl` pulse also sets done in the next cycle. With the mask at 0, DMA completion leaves done unchanged.
- R7: With the access mode at 1, writing 1 to bit 4 clears the DMA flag and writing 0 leaves it unchanged. Each write uses the mode value held before that write.
- R8: With the access mode at 0, a write loads bit 4 directly into the DMA flag.
- R9: When `dma_cmpl` arrives in the same cycle as a software write of bit 4, the flag ends up set.
- R10: The access-mode bit keeps its value through a system reset, ignores writes while `rst_n` is low, and clears on a power-on reset.
- R11: Bits 3, 5 to 7 and 10 and above read 0, and writes to them have no effect.
- R12: `irq` equals the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears every flop |
| rst_n | input | 1 | System reset, active low, spares the access-mode bit |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Register read data, combinational |
| eng_start | input | 1 | Start pulse, clears done and error |
| eng_done | input | 1 | Engine finished pulse |
| eng_err | input | 1 | Engine error pulse |
| eng_busy | input | 1 | Engine busy level |
| dma_cmpl | input | 1 | DMA transfer complete pulse |
| irq | output | 1 | Level interrupt that follows done |

## Verification
The in-line properties check the per-cycle rules on every clock: a set pulse shows up in the next cycle, set flags hold until a clear, the mask routes DMA completion into done, a write of 0 under write-1-to-clear leaves the flag unchanged, a direct write loads the flag, and the mode bit holds during system reset. The bench sweeps every combination of access mode, mask, starting flag value, written bit and simultaneous hardware set, and computes each expected value with arithmetic. The following can only be shown by scenarios at the ports: that the mode bit survives a system reset but not a power-on reset, that reserved bits stay 0 after a write of all ones, and that ready follows the busy level.

// File: rtl/csr_pkg.sv
package csr_pkg;
    localparam int DONE_BIT  = 0;
    localparam int READY_BIT = 1;
    localparam int ERR_BIT   = 2;
    localparam int DMA_BIT   = 4;
    localparam int MASK_BIT  = 8;
    localparam int MODE_BIT  = 9;
    localparam int MIN_W     = MODE_BIT + 1;

    typedef struct packed {
        logic route_mask;
    } cfg_t;

    typedef struct packed {
        logic flag;
    } dma_st_t;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr_i) q_d = 1'b0;
        if (set_i) q_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    // R3 / R4: set pulse appears next cycle, even against a clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
    // R3 / R4: flag is sticky without a clear
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr_i) |=> q);
endmodule

// File: rtl/dma_flag.sv
module dma_flag import csr_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic w1c_i,
    output logic q
);
    dma_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            if (w1c_i) begin
                if (wbit_i) st_d.flag = 1'b0;
            end else begin
                st_d.flag = wbit_i;
            end
        end
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.flag;

    a_r9_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q);
    a_r7_w1c_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i && wr_i && !wbit_i && !set_i) |=> $stable(q));
    a_r8_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!w1c_i && wr_i && !set_i) |=> (q == $past(wbit_i)));
endmodule

// File: rtl/mode_reg.sv
module mode_reg (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wbit_i,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (wr_i && rst_n) q_d = wbit_i;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    a_r10_mode_hold: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> $stable(q));
endmodule

// File: rtl/cmpl_status_reg.sv
module cmpl_status_reg import csr_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              eng_start,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_busy,
    input  logic              dma_cmpl,
    output logic              irq
);
    localparam int SPARE_W = DATA_W - MIN_W;

    logic sys_rst_n;
    logic done_q, err_q, dma_q, mode_q;
    cfg_t cfg_d, cfg_q;

    assign sys_rst_n = rst_n & por_n;

    sticky_flag u_done (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .set_i (eng_done | (dma_cmpl & cfg_q.route_mask)),
        .clr_i ((wr_en & wr_data[DONE_BIT]) | eng_start),
        .q     (done_q)
    );

    sticky_flag u_err (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .set_i (eng_err),
        .clr_i ((wr_en & wr_data[ERR_BIT]) | eng_start),
        .q     (err_q)
    );

    dma_flag u_dma (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .set_i  (dma_cmpl),
        .wr_i   (wr_en),
        .wbit_i (wr_data[DMA_BIT]),
        .w1c_i  (mode_q),
        .q      (dma_q)
    );

    mode_reg u_mode (
        .clk    (clk),
        .por_n  (por_n),
        .rst_n  (rst_n),
        .wr_i   (wr_en),
        .wbit_i (wr_data[MODE_BIT]),
        .q      (mode_q)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d.route_mask = wr_data[MASK_BIT];
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) cfg_q <= '0;
        else            cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data            = '0;
        rd_data[DONE_BIT]  = done_q;
        rd_data[READY_BIT] = ~eng_busy;
        rd_data[ERR_BIT]   = err_q;
        rd_data[DMA_BIT]   = dma_q;
        rd_data[MASK_BIT]  = cfg_q.route_mask;
        rd_data[MODE_BIT]  = mode_q;
    end

    assign irq = done_q;

    initial begin
        a_r11_width_ok: assert (SPARE_W >= 0);
    end

    a_r6_mask_routes: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (dma_cmpl && cfg_q.route_mask) |=> rd_data[DONE_BIT]);
    a_r5_dma_sets: assert property (@(posedge clk) disable iff (!sys_rst_n)
        dma_cmpl |=> rd_data[DMA_BIT]);
endmodule

// File: tb/test_cmpl_status_reg.sv
module test_cmpl_status_reg;
    localparam int PERIOD = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic eng_start = 1'b0, eng_done = 1'b0, eng_err = 1'b0, eng_busy = 1'b0, dma_cmpl = 1'b0;
    logic irq;
    int n_chk = 0, n_fail = 0;
    logic mode_m = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    cmpl_status_reg #(.DATA_W(DW)) i_cmpl_status_reg (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .eng_start(eng_start), .eng_done(eng_done), .eng_err(eng_err),
        .eng_busy(eng_busy), .dma_cmpl(dma_cmpl), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        eng_start = 1'b0; eng_done = 1'b0; eng_err = 1'b0; dma_cmpl = 1'b0;
    endtask

    task automatic write(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state: only ready set while idle
        check("R1 reset", rd_data, 32'h2);

        // R2 ready follows busy in the same cycle
        eng_busy = 1'b1; #1;
        check("R2 busy", {31'b0, rd_data[1]}, 32'd0);
        eng_busy = 1'b0; #1;
        check("R2 idle", {31'b0, rd_data[1]}, 32'd1);

        // R3 done set, sticky, cleared, set wins
        eng_done = 1'b1; step();
        check("R3 set", {31'b0, rd_data[0]}, 32'd1);
        check("R12 irq", {31'b0, irq}, 32'd1);
        step(); step();
        check("R3 sticky", {31'b0, rd_data[0]}, 32'd1);
        write(32'h0);
        check("R3 write0 keeps", {31'b0, rd_data[0]}, 32'd1);
        write(32'h1);
        check("R3 w1c", {31'b0, rd_data[0]}, 32'd0);
        check("R12 irq low", {31'b0, irq}, 32'd0);
        eng_done = 1'b1; wr_en = 1'b1; wr_data = 32'h1; step();
        check("R3 set wins", {31'b0, rd_data[0]}, 32'd1);
        eng_start = 1'b1; step();
        check("R3 start clears", {31'b0, rd_data[0]}, 32'd0);
        eng_done = 1'b1; eng_start = 1'b1; step();
        check("R3 set beats start", {31'b0, rd_data[0]}, 32'd1);
        write(32'h1);

        // R4 error
        eng_err = 1'b1; step(); step();
        check("R4 sticky", {31'b0, rd_data[2]}, 32'd1);
        write(32'h4);
        check("R4 w1c", {31'b0, rd_data[2]}, 32'd0);
        eng_err = 1'b1; step();
        eng_start = 1'b1; step();
        check("R4 start clears", {31'b0, rd_data[2]}, 32'd0);
        eng_err = 1'b1; wr_en = 1'b1; wr_data = 32'h4; step();
        check("R4 set wins", {31'b0, rd_data[2]}, 32'd1);
        write(32'h4);

        // R5-R9 sweep: mode x mask x initial flag x written bit x hw set
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 2; k++)
                for (int i = 0; i < 2; i++)
                    for (int w = 0; w < 2; w++)
                        for (int h = 0; h < 2; h++) begin
                            logic [DW-1:0] cfg;
                            logic exp_dma, exp_done;
                            cfg = (DW'(k) << 8) | (DW'(m) << 9);
                            write(cfg | 32'h5 | (mode_m ? 32'h10 : 32'h0));
                            mode_m = m[0];
                            check("R1 clean start", {31'b0, rd_data[4]}, 32'd0);
                            if (i != 0) begin dma_cmpl = 1'b1; step(); end
                            check("R5 dma set", {31'b0, rd_data[4]}, DW'(i));
                            check("R6 mask route", {31'b0, rd_data[0]}, DW'(i & k));
                            dma_cmpl = h[0];
                            write(cfg | (DW'(w) << 4));
                            if (h != 0) exp_dma = 1'b1;
                            else if (m != 0) exp_dma = i[0] & ~w[0];
                            else exp_dma = w[0];
                            exp_done = (i[0] | h[0]) & k[0];
                            check(h != 0 ? "R9 hw wins" : (m != 0 ? "R7 w1c" : "R8 direct"),
                                  {31'b0, rd_data[4]}, DW'(exp_dma));
                            check("R6 done", {31'b0, rd_data[0]}, DW'(exp_done));
                            check("R10 mode", {31'b0, rd_data[9]}, DW'(m));
                        end

        // R11 reserved bits after writing all ones (mode is 1 now)
        write('1);
        check("R11 reserved", rd_data & ~32'h317, 32'd0);
        check("R11 known", rd_data & 32'h317, 32'h302);

        // R10 mode survives system reset, writes ignored while in reset
        rst_n = 1'b0; wr_en = 1'b1; wr_data = 32'h0;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        check("R10 mode held in sys reset", {31'b0, rd_data[9]}, 32'd1);
        rst_n = 1'b1; @(negedge clk);
        check("R1 sys reset clears mask", {31'b0, rd_data[8]}, 32'd0);
        check("R10 mode survives", {31'b0, rd_data[9]}, 32'd1);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
        check("R10 por clears mode", rd_data, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule